// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block holds the programming state of an interrupt router: one 64-bit redirection entry for each input pin, a 4-bit identification value and a fixed version word. Software reaches all of it through two locations on a simple bus. A selector register at offset 0x00 chooses an internal register. A 32-bit data window at offset 0x10 reads or writes the chosen register. Each table entry takes two selector values, one for each 32-bit half.

The delivery logic receives the whole table as one flat vector. It raises a per-pin strobe to set an entry's remote-IRR status bit (bit 14), which the bus can never set. A lower-half write clears it. Each entry also carries a vector in bits 7:0, a delivery mode in 10:8, a destination mode in bit 11, a trigger mode in bit 15, a mask in bit 16 and a destination in bits 63:56. When a bus write changes an entry's mask bit, the block emits a one-cycle notice that carries the entry number and the new mask value.

Top module: `irq_route_regfile`

## Requirements
- R1: A write to offset 0x00 keeps bits 7:0 of the size-adjusted data as the selector. A read of offset 0x00 returns the selector zero-extended to 32 bits. Address bits above bit 7 take no part in decoding.
- R2: A read at any offset other than 0x00 and 0x10 (low address byte) returns zero. A write there changes nothing.
- R3: Selector 0x01 reads as (pin count − 1) in bits 23:16 and 0x11 in bits 7:0. With 24 pins this is 0x00170011. Writes to it are ignored.
- R4: Selectors 0x00 and 0x02 both read the 4-bit ID in bits 27:24, with all other bits zero. A window write with selector 0x00 stores data bits 27:24 as the ID. A window write with selector 0x02 is ignored.
- R5: A selector s ≥ 0x10 addresses entry (s − 0x10) >> 1. If s is odd the access goes to bits 63:32 of that entry, and if s is even it goes to bits 31:0. A write stores the 32-bit half and a read returns it. The entry appears in bits [64·n +: 64] of the table output.
- R6: A selector whose entry number is 24 or more reads as 0xFFFFFFFF, and so does any selector from 0x03 to 0x0F. A window write with such a selector changes no entry.
- R7: Bit 14 of an entry is set only by that pin's set strobe. A lower-half write forces it to 0, whatever the data bit holds, and this clear takes priority over a set in the same cycle. An upper-half write leaves it unchanged.
- R8: Write data depends on the length field. Lengths 8 and 4 use all 32 bits, length 2 uses bits 15:0 zero-extended and length 1 uses bits 7:0 zero-extended. With any other length the write is dropped.
- R9: After reset every entry reads 0x0000000000010000 (mask set, all else zero), and the selector and the ID are zero.
- R10: In the cycle after a lower-half write that changes an entry's mask bit (bit 16), the block asserts the notice output for one cycle with that entry number and the new mask value. A write that leaves the mask unchanged produces no notice.
- R11: The read data and its valid flag appear in the cycle after the read strobe. The valid flag is low in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_len | input | LEN_W | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| rirr_set | input | PINS | Per-pin strobe that sets the entry's remote-IRR bit |
| route_tbl | output | PINS*64 | All entries, entry n in bits [64n +: 64] |
| mchg_valid | output | 1 | Mask-change notice |
| mchg_idx | output | ENT_W | Entry whose mask changed |
| mchg_mask | output | 1 | New mask value |

## Verification
The bench targets the selector arithmetic at its edges: entry 23 and the first entry past the table, the gap from 0x03 to 0x0F, and 0xFF. An off-by-one range test would alias selector 0x40 onto a real entry, and a wrap in the subtraction would turn the gap into live entries. It tries to set the remote-IRR bit from the bus and checks that an upper-half write leaves the bit alone, which catches a design that stores bit 14 as plain data. It sends 1-, 2- and 3-byte writes, where a missing zero-extension leaves stray high bits and an accepted odd length corrupts an entry. It also pairs a write that flips the mask with one that does not, so that a notice on every write, or a notice carrying the old mask value, is caught.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ENTRY_W  = 64;
    localparam int unsigned SEL_W    = 8;
    localparam int unsigned TBL_BASE = 16;

    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;

    localparam logic [SEL_W-1:0] SEL_ID  = 8'h00;
    localparam logic [SEL_W-1:0] SEL_VER = 8'h01;
    localparam logic [SEL_W-1:0] SEL_ARB = 8'h02;

    // entry field positions that behaviour depends on
    localparam int unsigned F_RIRR = 14;
    localparam int unsigned F_MASK = 16;
    localparam int unsigned ID_LSB = 24;
endpackage

// File: rtl/irq_route_wshape.sv
module irq_route_wshape
    import irq_route_pkg::*;
#(
    parameter int unsigned LEN_W = 4
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] shaped,
    output logic              ok
);
    always_comb begin
        shaped = '0;
        ok     = 1'b1;
        case (len)
            LEN_W'(8), LEN_W'(4): shaped = raw;
            LEN_W'(2):            shaped = {16'h0000, raw[15:0]};
            LEN_W'(1):            shaped = {24'h000000, raw[7:0]};
            default:              ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rirr_set,
    output logic [ENTRY_W-1:0] ent_q,
    output logic               mask_flip
);
    localparam logic [ENTRY_W-1:0] RST_VAL = ENTRY_W'(1) << F_MASK;

    logic [ENTRY_W-1:0] ent_d;

    always_comb begin
        ent_d = ent_q;
        if (rirr_set) ent_d[F_RIRR] = 1'b1;
        if (wr_hi)    ent_d[ENTRY_W-1:DATA_W] = wdata;
        if (wr_lo) begin
            ent_d[DATA_W-1:0] = wdata;
            ent_d[F_RIRR]     = 1'b0;   // bus clear wins over status set
        end
    end

    assign mask_flip = wr_lo && (wdata[F_MASK] != ent_q[F_MASK]);

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= RST_VAL;
        else        ent_q <= ent_d;
    end
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irq_route_pkg::*;
#(
    parameter int unsigned PINS     = 24,
    parameter logic [7:0]  VER_CODE = 8'h11,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LEN_W    = 4,
    localparam int unsigned ENT_W   = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic [LEN_W-1:0]        bus_len,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_rvalid,
    input  logic [PINS-1:0]         rirr_set,
    output logic [PINS*ENTRY_W-1:0] route_tbl,
    output logic                    mchg_valid,
    output logic [ENT_W-1:0]        mchg_idx,
    output logic                    mchg_mask
);
    localparam logic [6:0]        PINS_LIM = 7'(PINS);
    localparam logic [DATA_W-1:0] VER_WORD = {8'h00, 8'(PINS - 1), 8'h00, VER_CODE};

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [3:0]        id;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              mv;
        logic [ENT_W-1:0]  mi;
        logic              mm;
    } regs_t;

    regs_t st_d, st_q;

    // address decode
    logic [7:0] off;
    logic       hit_sel, hit_win;
    logic       unused_hi;
    assign off       = bus_addr[7:0];
    assign hit_sel   = (off == OFF_SEL);
    assign hit_win   = (off == OFF_WIN);
    assign unused_hi = ^bus_addr[ADDR_W-1:8];

    // write data shaping
    logic [DATA_W-1:0] wdat;
    logic              wok;
    irq_route_wshape #(.LEN_W(LEN_W)) u_wshape (
        .len    (bus_len),
        .raw    (bus_wdata),
        .shaped (wdat),
        .ok     (wok)
    );

    // selector to table entry
    logic [SEL_W-1:0] rel;
    logic [6:0]       ent_num;
    logic [ENT_W-1:0] ent_idx;
    logic             tbl_hit, half_hi, win_wr;
    assign rel     = st_q.sel - SEL_W'(TBL_BASE);
    assign ent_num = rel[7:1];
    assign ent_idx = ent_num[ENT_W-1:0];
    assign tbl_hit = (st_q.sel >= SEL_W'(TBL_BASE)) && (ent_num < PINS_LIM);
    assign half_hi = st_q.sel[0];
    assign win_wr  = bus_wr && wok && hit_win;

    // entry array
    logic [ENTRY_W-1:0] ent_bits [PINS];
    logic [PINS-1:0]    wr_lo_v, wr_hi_v, flip_v;

    for (genvar g = 0; g < PINS; g++) begin : g_ent
        assign wr_lo_v[g] = win_wr && tbl_hit && (ent_idx == ENT_W'(g)) && !half_hi;
        assign wr_hi_v[g] = win_wr && tbl_hit && (ent_idx == ENT_W'(g)) &&  half_hi;

        irq_route_entry u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (wr_lo_v[g]),
            .wr_hi     (wr_hi_v[g]),
            .wdata     (wdat),
            .rirr_set  (rirr_set[g]),
            .ent_q     (ent_bits[g]),
            .mask_flip (flip_v[g])
        );

        assign route_tbl[g*ENTRY_W +: ENTRY_W] = ent_bits[g];
    end

    // window read value
    logic [ENTRY_W-1:0] ent_rd;
    logic [DATA_W-1:0]  win_val;
    always_comb begin
        ent_rd = '0;
        if (tbl_hit) ent_rd = ent_bits[ent_idx];
        case (st_q.sel)
            SEL_VER:         win_val = VER_WORD;
            SEL_ID, SEL_ARB: win_val = {4'h0, st_q.id, 24'h000000};
            default: begin
                if (!tbl_hit)     win_val = '1;
                else if (half_hi) win_val = ent_rd[ENTRY_W-1:DATA_W];
                else              win_val = ent_rd[DATA_W-1:0];
            end
        endcase
    end

    // next state
    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_rd;
        st_d.rdata  = '0;
        if (bus_rd) begin
            if (hit_sel)      st_d.rdata = {{(DATA_W-SEL_W){1'b0}}, st_q.sel};
            else if (hit_win) st_d.rdata = win_val;
        end
        if (bus_wr && wok) begin
            if (hit_sel) st_d.sel = wdat[SEL_W-1:0];
            else if (hit_win && st_q.sel == SEL_ID) st_d.id = wdat[ID_LSB+3:ID_LSB];
        end
        st_d.mv = |flip_v;
        if (|flip_v) begin
            st_d.mi = ent_idx;
            st_d.mm = wdat[F_MASK];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign mchg_valid = st_q.mv;
    assign mchg_idx   = st_q.mi;
    assign mchg_mask  = st_q.mm;
endmodule

// File: rtl/irq_route_regfile_chk.sv
module irq_route_regfile_chk #(
    parameter int unsigned PINS  = 24,
    parameter int unsigned ENT_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         addr_lo,
    input logic               bus_rd,
    input logic [31:0]        bus_rdata,
    input logic               bus_rvalid,
    input logic [PINS-1:0]    rirr_set,
    input logic [PINS*64-1:0] route_tbl,
    input logic               mchg_valid,
    input logic [ENT_W-1:0]   mchg_idx,
    input logic               mchg_mask
);
    assert_rvalid_after_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_rvalid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    assert_stray_offset_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && addr_lo != 8'h00 && addr_lo != 8'h10) |=> (bus_rdata == 32'h0));

    assert_sel_read_narrow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && addr_lo == 8'h00) |=> (bus_rdata[31:8] == 24'h0));

    assert_notice_matches_table_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_valid |-> (route_tbl[32'(mchg_idx)*64 + 16] == mchg_mask));

    for (genvar g = 0; g < PINS; g++) begin : g_rirr
        assert_rirr_only_by_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(route_tbl[g*64 + 14]) |-> $past(rirr_set[g]));
    end
endmodule

bind irq_route_regfile irq_route_regfile_chk #(.PINS(PINS), .ENT_W(ENT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_lo    (bus_addr[7:0]),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .rirr_set   (rirr_set),
    .route_tbl  (route_tbl),
    .mchg_valid (mchg_valid),
    .mchg_idx   (mchg_idx),
    .mchg_mask  (mchg_mask)
);

// File: tb/irq_route_regfile_test.sv
`timescale 1ns/1ps
module irq_route_regfile_test;
    localparam int PINS = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       bus_addr = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_len = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [PINS-1:0]   rirr_set = '0;
    logic [PINS*64-1:0] route_tbl;
    logic              mchg_valid;
    logic [4:0]        mchg_idx;
    logic              mchg_mask;

    always #4 clk = ~clk;

    irq_route_regfile uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .rirr_set(rirr_set), .route_tbl(route_tbl), .mchg_valid(mchg_valid),
        .mchg_idx(mchg_idx), .mchg_mask(mchg_mask)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read results against the scoreboard queue
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (bus_rvalid) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R11 unexpected read data: actual %h expected none", bus_rdata);
                end else begin
                    check(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
                end
            end
        end
    end

    task automatic bus_write(input logic [31:0] a, input logic [3:0] len, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_len = len; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_sel(input logic [7:0] s);
        bus_write(32'h0, 4'd4, {24'h0, s});
    endtask

    task automatic notice(input string tag, input logic v, input logic [4:0] idx, input logic m);
        check({tag, " valid"}, 64'(mchg_valid), 64'(v));
        if (v) begin
            check({tag, " idx"}, 64'(mchg_idx), 64'(idx));
            check({tag, " mask"}, 64'(mchg_mask), 64'(m));
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [PINS*64-1:0] snap;
        logic               ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        ok = 1'b1;
        for (int i = 0; i < PINS; i++)
            if (route_tbl[i*64 +: 64] !== 64'h0000_0000_0001_0000) ok = 1'b0;
        check("R9 table reset", 64'(ok), 64'd1);
        check("R11 rvalid idle after reset", 64'(bus_rvalid), 64'd0);
        check("R10 no notice after reset", 64'(mchg_valid), 64'd0);
        bus_read(32'h00, 32'h0, "R9 selector reset");
        bus_read(32'h10, 32'h0, "R9 id reset");
        @(negedge clk);
        check("R11 rvalid drops", 64'(bus_rvalid), 64'd0);

        // R1 selector, high address bits ignored
        bus_write(32'hABCD_0000, 4'd4, 32'h1234_5601);
        bus_read(32'hFFFF_FF00, 32'h01, "R1 selector low byte");
        // R3 version
        bus_read(32'h10, 32'h0017_0011, "R3 version word");
        bus_write(32'h10, 4'd4, 32'hFFFF_FFFF);
        bus_read(32'h10, 32'h0017_0011, "R3 version write ignored");

        // R4 id
        set_sel(8'h00);
        bus_write(32'h10, 4'd4, 32'hA500_0000);
        bus_read(32'h10, 32'h0500_0000, "R4 id write/read");
        set_sel(8'h02);
        bus_read(32'h10, 32'h0500_0000, "R4 alias read");
        bus_write(32'h10, 4'd4, 32'h0F00_0000);
        bus_read(32'h10, 32'h0500_0000, "R4 alias write ignored");

        // R5 table halves, R10 notice
        set_sel(8'h1A);
        bus_write(32'h10, 4'd4, 32'h0000_A931);
        notice("R10 unmask entry 5", 1'b1, 5'd5, 1'b0);
        bus_read(32'h10, 32'h0000_A931, "R5 entry5 low");
        set_sel(8'h1B);
        bus_write(32'h10, 4'd4, 32'h7F00_0000);
        notice("R10 upper write no notice", 1'b0, 5'd0, 1'b0);
        bus_read(32'h10, 32'h7F00_0000, "R5 entry5 high");
        check("R5 entry5 on table", route_tbl[5*64 +: 64], 64'h7F00_0000_0000_A931);
        set_sel(8'h3F);
        bus_write(32'h10, 4'd4, 32'hDEAD_BEEF);
        bus_read(32'h10, 32'hDEAD_BEEF, "R5 last entry high");
        set_sel(8'h3E);
        bus_read(32'h10, 32'h0001_0000, "R5 last entry low");

        // R6 out of range
        snap = route_tbl;
        set_sel(8'h40);
        bus_write(32'h10, 4'd4, 32'h1234_5678);
        check("R6 write past table dropped", 64'(route_tbl == snap), 64'd1);
        bus_read(32'h10, 32'hFFFF_FFFF, "R6 sel 0x40");
        set_sel(8'h41);
        bus_read(32'h10, 32'hFFFF_FFFF, "R6 sel 0x41");
        set_sel(8'hFF);
        bus_read(32'h10, 32'hFFFF_FFFF, "R6 sel 0xFF");
        set_sel(8'h05);
        bus_read(32'h10, 32'hFFFF_FFFF, "R6 sel 0x05");
        set_sel(8'h07);
        bus_write(32'h10, 4'd4, 32'h0);
        check("R6 gap write dropped", 64'(route_tbl == snap), 64'd1);

        // R7 remote-IRR
        @(negedge clk);
        rirr_set = PINS'(1) << 5;
        @(negedge clk);
        rirr_set = '0;
        set_sel(8'h1A);
        bus_read(32'h10, 32'h0000_E931, "R7 set by strobe");
        set_sel(8'h1B);
        bus_write(32'h10, 4'd4, 32'h0100_0000);
        set_sel(8'h1A);
        bus_read(32'h10, 32'h0000_E931, "R7 upper write keeps");
        bus_write(32'h10, 4'd4, 32'h0000_E931);
        notice("R10 same mask no notice", 1'b0, 5'd0, 1'b0);
        bus_read(32'h10, 32'h0000_A931, "R7 low write clears");

        // R8 access length
        set_sel(8'h14);
        bus_write(32'h10, 4'd2, 32'hFFFF_1234);
        notice("R10 unmask entry 2", 1'b1, 5'd2, 1'b0);
        bus_read(32'h10, 32'h0000_1234, "R8 two-byte");
        bus_write(32'h10, 4'd1, 32'hFFFF_FF56);
        bus_read(32'h10, 32'h0000_0056, "R8 one-byte");
        bus_write(32'h10, 4'd3, 32'h0001_0000);
        notice("R8 bad length no notice", 1'b0, 5'd0, 1'b0);
        bus_read(32'h10, 32'h0000_0056, "R8 bad length dropped");
        bus_write(32'h10, 4'd8, 32'h0001_0077);
        notice("R10 mask entry 2", 1'b1, 5'd2, 1'b1);
        bus_read(32'h10, 32'h0001_0077, "R8 eight-byte");
        bus_write(32'h00, 4'd0, 32'h0000_0030);
        bus_read(32'h00, 32'h0000_0014, "R8 bad length on selector");

        // R2 stray offsets
        bus_read(32'h04, 32'h0, "R2 offset 0x04");
        bus_read(32'h20, 32'h0, "R2 offset 0x20");
        bus_read(32'h1C, 32'h0, "R2 offset 0x1C");
        bus_write(32'h20, 4'd4, 32'h0000_0099);
        bus_read(32'h00, 32'h0000_0014, "R2 stray write ignored");

        repeat (3) @(negedge clk);
        check("R11 all reads answered", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule